// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This block reorders the 16-bit channel words of two framed input streams into one framed output stream. A frame has `NCH` timeslots and one clock per timeslot. Each timeslot, the word on each input is written into that stream's data memory at the slot's index. For every output timeslot, a connection entry names the source slot and the stream to read. It can also replace the data with a constant from the entry, blank the slot, or raise an enable for an external bus driver one slot early.

The connection entries are written and read by a processor through a plain word port. Each frame the entries are scanned into the switch path. A 16-bit CRC is folded over the scanned entries and compared with a stored reference. Any unexpected change pulls an active-low alert low until the processor acknowledges it.

Top module: `tsi_switch`

## Requirements
- R1: The slot counter is 0 after reset, steps by one per clock and wraps from NCH-1 to 0. A clock edge that samples `fsync` high makes the next slot 0, whatever the count.
- R2: The word on `din_a`/`din_b` during slot s of frame f is stored for source s of that stream. An output slot o of frame f that selects source s delivers the frame f word if s < o, and the frame f-1 word if s >= o.
- R3: The output for output channel o appears on `dout`/`dout_en` in the second cycle after the cycle whose slot is o.
- R4: Connection entry layout: [9:0] source slot (low log2(NCH) bits address the memory), [10] drive enable, [11] constant mode, [12] stream select (0 = `din_a`, 1 = `din_b`), [13] bus-enable bit, [15:14] spare.
- R5: With entry bit 10 at 0, `dout_en` is 0 and `dout` is 0 for that slot, whatever bit 11 says.
- R6: With bits 10 and 11 at 1, `dout` is entry bits [9:0] zero-extended to DW, and no data memory word is used.
- R7: Entry bit 13 of output channel o drives `ext_en` in the cycle before that channel's word, that is one cycle after slot o.
- R8: A processor write never changes the frame in progress. It takes effect in the next frame if the scan has not yet reached that entry in the current frame, and otherwise in the frame after.
- R9: A read request returns the stored 16-bit entry on `cpu_rdata` in the next cycle. `cpu_rdata` holds its value while no read is requested.
- R10: `cd_n` is 1 after reset. The first complete scan stores the CRC reference. A later complete scan whose CRC differs drives `cd_n` low, and it stays low until acknowledged.
- R11: `cd_ack` raises `cd_n` in the next cycle. The reference is reloaded at the end of the next complete scan, so unchanged entries keep `cd_n` high from then on.
- R12: Reset leaves `dout`, `dout_en`, `ext_en` and `cpu_rdata` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timeslot per cycle |
| rst | input | 1 | Synchronous reset, active high |
| fsync | input | 1 | Frame pulse, forces slot 0 next cycle |
| din_a | input | DW | Input stream 0 word for the current slot |
| din_b | input | DW | Input stream 1 word for the current slot |
| dout | output | DW | Switched output word |
| dout_en | output | 1 | Output slot driven |
| ext_en | output | 1 | External bus enable, one slot early |
| cpu_we | input | 1 | Connection entry write strobe |
| cpu_re | input | 1 | Connection entry read request |
| cpu_addr | input | log2(NCH) | Entry index |
| cpu_wdata | input | 16 | Entry write data |
| cpu_rdata | output | 16 | Entry read data |
| cd_ack | input | 1 | Change-alert acknowledge |
| cd_n | output | 1 | Change alert, active low |

## Verification
The hardest case to reach is the boundary of R8: a write that lands just before the scan reaches its entry, against one that lands just after. The bench tracks the slot count itself and issues one write at slot 2 to entry 10 and another at slot 3 to entry 1. It then expects the first to take effect one frame later and the second two frames later, and it checks that the frame in progress is unchanged. Every output slot is compared over several frames under two permutations, with the past/current frame rule of R2 worked out per slot, and a mid-frame frame pulse is checked through constant-mode entries that echo the channel index.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

   localparam int CM_W    = 16;
   localparam int SRC_W   = 10;
   localparam int NSTREAM = 2;

   typedef struct packed {
      logic [1:0]       spare;
      logic             ext;
      logic             bank;
      logic             msg;
      logic             oe;
      logic [SRC_W-1:0] src;
   } cm_word_t;

   function automatic logic [15:0] crc16_step(input logic [15:0] c,
                                              input logic [15:0] d,
                                              input logic [15:0] poly);
      logic [15:0] r;
      logic        fb;
      r = c;
      for (int i = 15; i >= 0; i--) begin
         fb = r[15] ^ d[i];
         r  = {r[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
      end
      return r;
   endfunction

endpackage

// File: rtl/tsi_slot_ctr.sv
module tsi_slot_ctr #(
   parameter int NCH = 1024,
   localparam int AW = $clog2(NCH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          fsync,
   output logic [AW-1:0] slot
);
   localparam logic [AW-1:0] LAST = AW'(NCH - 1);

   always_ff @(posedge clk) begin
      if (rst)               slot <= '0;
      else if (fsync)        slot <= '0;
      else if (slot == LAST) slot <= '0;
      else                   slot <= slot + 1'b1;
   end
endmodule

// File: rtl/tsi_data_store.sv
module tsi_data_store #(
   parameter int NCH = 1024,
   parameter int DW  = 16,
   parameter int NS  = tsi_pkg::NSTREAM,
   localparam int AW = $clog2(NCH),
   localparam int BW = (NS > 1) ? $clog2(NS) : 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [AW-1:0]         slot,
   input  logic [NS-1:0][DW-1:0] din,
   input  logic [AW-1:0]         rd_addr,
   input  logic [BW-1:0]         rd_bank,
   output logic [DW-1:0]         rd_word
);
   logic [AW-1:0]         wa_q;
   logic [BW-1:0]         bank_q;
   logic [NS-1:0][DW-1:0] rd_all;

   always_ff @(posedge clk) begin
      if (rst) begin
         wa_q   <= '0;
         bank_q <= '0;
      end else begin
         wa_q   <= slot;
         bank_q <= rd_bank;
      end
   end

   for (genvar k = 0; k < NS; k++) begin : g_bank
      logic [DW-1:0] mem [NCH];
      logic [DW-1:0] din_q;
      logic [DW-1:0] rd_r;

      always_ff @(posedge clk) begin
         din_q     <= din[k];
         mem[wa_q] <= din_q;
         rd_r      <= mem[rd_addr];
      end
      assign rd_all[k] = rd_r;
   end

   assign rd_word = rd_all[bank_q];
endmodule

// File: rtl/tsi_conn_store.sv
module tsi_conn_store #(
   parameter int NCH = 1024,
   localparam int AW = $clog2(NCH)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [AW-1:0]            slot,
   input  logic                     cpu_we,
   input  logic                     cpu_re,
   input  logic [AW-1:0]            cpu_addr,
   input  logic [tsi_pkg::CM_W-1:0] cpu_wdata,
   output logic [tsi_pkg::CM_W-1:0] cpu_rdata,
   output tsi_pkg::cm_word_t        scan_word,
   output logic [AW-1:0]            scan_idx,
   output logic                     scan_vld
);
   logic [tsi_pkg::CM_W-1:0] shadow [NCH];
   logic [tsi_pkg::CM_W-1:0] active [NCH];

   // processor side lands in the shadow copy; the scan refreshes one
   // active entry per slot right after using it
   always_ff @(posedge clk) begin
      if (cpu_we) shadow[cpu_addr] <= cpu_wdata;
      active[slot] <= shadow[slot];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         scan_word <= '0;
         scan_idx  <= '0;
         scan_vld  <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         scan_word <= tsi_pkg::cm_word_t'(active[slot]);
         scan_idx  <= slot;
         scan_vld  <= 1'b1;
         if (cpu_re) cpu_rdata <= shadow[cpu_addr];
      end
   end
endmodule

// File: rtl/tsi_change_det.sv
module tsi_change_det #(
   parameter int          NCH  = 1024,
   parameter logic [15:0] POLY = 16'h1021,
   parameter logic [15:0] SEED = 16'hFFFF,
   localparam int AW = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst,
   input  tsi_pkg::cm_word_t scan_word,
   input  logic [AW-1:0]     scan_idx,
   input  logic              scan_vld,
   input  logic              ack,
   output logic              cd_n
);
   localparam logic [AW-1:0] LAST = AW'(NCH - 1);

   logic [15:0] acc, ref_q, nxt;
   logic        have_ref, reload;

   always_comb nxt = tsi_pkg::crc16_step((scan_idx == '0) ? SEED : acc,
                                         scan_word, POLY);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc      <= '0;
         ref_q    <= '0;
         have_ref <= 1'b0;
         reload   <= 1'b0;
         cd_n     <= 1'b1;
      end else begin
         if (ack) begin
            cd_n   <= 1'b1;
            reload <= 1'b1;
         end
         if (scan_vld) begin
            acc <= nxt;
            if (scan_idx == LAST) begin
               if (!have_ref || reload || ack) begin
                  ref_q    <= nxt;
                  have_ref <= 1'b1;
                  reload   <= 1'b0;
               end else if (nxt != ref_q) begin
                  cd_n <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
   parameter int          NCH      = 1024,
   parameter int          DW       = 16,
   parameter logic [15:0] CRC_POLY = 16'h1021,
   localparam int AW = $clog2(NCH)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     fsync,
   input  logic [DW-1:0]            din_a,
   input  logic [DW-1:0]            din_b,
   output logic [DW-1:0]            dout,
   output logic                     dout_en,
   output logic                     ext_en,
   input  logic                     cpu_we,
   input  logic                     cpu_re,
   input  logic [AW-1:0]            cpu_addr,
   input  logic [tsi_pkg::CM_W-1:0] cpu_wdata,
   output logic [tsi_pkg::CM_W-1:0] cpu_rdata,
   input  logic                     cd_ack,
   output logic                     cd_n
);
   import tsi_pkg::*;

   if (NCH < 2 || NCH > 1024 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("NCH must be a power of two from 2 to 1024");
   end
   if (DW < SRC_W) begin : g_bad_dw
      $error("DW must hold the 10-bit constant field");
   end

   logic [AW-1:0]               slot;
   cm_word_t                    scan_word;
   logic [AW-1:0]               scan_idx;
   logic                        scan_vld;
   logic [NSTREAM-1:0][DW-1:0]  din_bus;
   logic [DW-1:0]               rd_word;
   logic [DW-1:0]               msg_word;
   logic                        oe_q, msg_q;
   logic [SRC_W-1:0]            src_q;

   assign din_bus = {din_b, din_a};

   tsi_slot_ctr #(.NCH(NCH)) u_ctr (
      .clk(clk), .rst(rst), .fsync(fsync), .slot(slot));

   tsi_conn_store #(.NCH(NCH)) u_conn (
      .clk(clk), .rst(rst), .slot(slot),
      .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .scan_word(scan_word), .scan_idx(scan_idx), .scan_vld(scan_vld));

   tsi_data_store #(.NCH(NCH), .DW(DW), .NS(NSTREAM)) u_data (
      .clk(clk), .rst(rst), .slot(slot), .din(din_bus),
      .rd_addr(scan_word.src[AW-1:0]), .rd_bank(scan_word.bank),
      .rd_word(rd_word));

   tsi_change_det #(.NCH(NCH), .POLY(CRC_POLY)) u_cd (
      .clk(clk), .rst(rst), .scan_word(scan_word), .scan_idx(scan_idx),
      .scan_vld(scan_vld), .ack(cd_ack), .cd_n(cd_n));

   // control travels alongside the data read
   always_ff @(posedge clk) begin
      if (rst) begin
         oe_q  <= 1'b0;
         msg_q <= 1'b0;
         src_q <= '0;
      end else begin
         oe_q  <= scan_word.oe;
         msg_q <= scan_word.msg;
         src_q <= scan_word.src;
      end
   end

   if (DW > SRC_W) begin : g_msg_wide
      assign msg_word = {{(DW - SRC_W){1'b0}}, src_q};
   end else begin : g_msg_exact
      assign msg_word = src_q;
   end

   always_comb begin
      if (!oe_q)      dout = '0;
      else if (msg_q) dout = msg_word;
      else            dout = rd_word;
   end

   assign dout_en = oe_q;
   assign ext_en  = scan_word.ext;
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
   parameter int NCH = 1024,
   parameter int DW  = 16,
   localparam int AW = $clog2(NCH)
) (
   input logic          clk,
   input logic          rst,
   input logic          fsync,
   input logic [AW-1:0] slot,
   input logic [DW-1:0] dout,
   input logic          dout_en,
   input logic          cpu_re,
   input logic [15:0]   cpu_rdata,
   input logic          cd_ack,
   input logic          cd_n
);
   localparam logic [AW-1:0] LAST = AW'(NCH - 1);

   // R1
   frame_zero_chk: assert property (@(posedge clk) disable iff (rst)
      fsync |=> slot == '0);

   // R1
   slot_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!fsync && slot != LAST) |=> slot == $past(slot) + 1'b1);

   // R5
   blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !dout_en |-> dout == '0);

   // R9
   rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !cpu_re |=> $stable(cpu_rdata));

   // R10
   alert_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (!cd_n && !cd_ack) |=> !cd_n);

   // R11
   ack_release_chk: assert property (@(posedge clk) disable iff (rst)
      cd_ack |=> cd_n);
endmodule

bind tsi_switch tsi_switch_chk #(.NCH(NCH), .DW(DW)) u_chk (
   .clk(clk), .rst(rst), .fsync(fsync), .slot(slot), .dout(dout),
   .dout_en(dout_en), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata),
   .cd_ack(cd_ack), .cd_n(cd_n));

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
   localparam int N  = 16;
   localparam int DW = 16;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          fsync = 1'b0;
   logic [DW-1:0] din_a = '0, din_b = '0;
   logic [DW-1:0] dout;
   logic          dout_en, ext_en;
   logic          cpu_we = 1'b0, cpu_re = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [15:0]   cpu_wdata = '0;
   logic [15:0]   cpu_rdata;
   logic          cd_ack = 1'b0;
   logic          cd_n;

   always #5 clk = ~clk;

   tsi_switch #(.NCH(N), .DW(DW)) uut (
      .clk(clk), .rst(rst), .fsync(fsync), .din_a(din_a), .din_b(din_b),
      .dout(dout), .dout_en(dout_en), .ext_en(ext_en),
      .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cd_ack(cd_ack), .cd_n(cd_n));

   int checks = 0, failures = 0;
   bit done = 0;

   // bench model of the slot counter and frame number
   int cnt = 0, fr = 0;
   logic [15:0] cm_exp  [N];
   logic [15:0] pend_val[N];
   int          pend_fr [N];
   bit          pend_vld[N];

   bit    chk_on = 0, r8_phase = 0;
   string tag_over = "";
   bit            we_req = 0, re_req = 0, ack_req = 0, fp_force = 0;
   logic [AW-1:0] addr_req = '0;
   logic [15:0]   wdata_req = '0;

   bit          e1_vld = 0, e2_vld = 0, e1_en, e2_en, e1_ext, e2_ext;
   logic [15:0] e1_d, e2_d;
   string       e1_tag, e2_tag;

   function automatic logic [15:0] word_of(int f, int k, int s);
      return 16'((((f + 64) % 32) << 11) | (k << 10) | s);
   endfunction

   function automatic logic [15:0] cmw(int src, bit oe, bit msg, bit bank, bit ext);
      return {2'b00, ext, bank, msg, oe, 10'(src)};
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h (slot model %0d frame %0d)",
                  req, what, act, exp, cnt, fr);
      end
   endtask

   task automatic drive_cycle();
      int o;
      logic [15:0] w;
      din_a    = word_of(fr, 0, cnt);
      din_b    = word_of(fr, 1, cnt);
      fsync    = (cnt == N - 1) || fp_force;
      cpu_we   = we_req;
      cpu_re   = re_req;
      cpu_addr = addr_req;
      cpu_wdata = wdata_req;
      cd_ack   = ack_req;
      we_req = 0; re_req = 0; ack_req = 0; fp_force = 0;
      // expectation for output channel o = cnt
      e2_vld = e1_vld; e2_d = e1_d; e2_en = e1_en; e2_ext = e1_ext; e2_tag = e1_tag;
      o = cnt;
      if (pend_vld[o] && fr >= pend_fr[o]) begin
         cm_exp[o]   = pend_val[o];
         pend_vld[o] = 0;
      end
      w = cm_exp[o];
      e1_vld = chk_on;
      e1_ext = w[13];
      e1_en  = w[10];
      if (!w[10])     e1_d = '0;
      else if (w[11]) e1_d = {6'b0, w[9:0]};
      else begin
         int s;
         s = int'(w[AW-1:0]);
         e1_d = word_of((s < o) ? fr : fr - 1, int'(w[12]), s);
      end
      if (tag_over != "")               e1_tag = tag_over;
      else if (r8_phase && (o == 1 || o == 10)) e1_tag = "R8";
      else if (!w[10])                  e1_tag = "R5";
      else if (w[11])                   e1_tag = "R6";
      else                              e1_tag = "R2 R4";
      // advance model to the next cycle
      if (fsync || cnt == N - 1) cnt = 0;
      else cnt = cnt + 1;
      if (cnt == 0) fr++;
   endtask

   task automatic tick();
      @(negedge clk);
      if (e2_vld) begin
         chk(e2_tag, "dout (R3 timing)", 32'(dout), 32'(e2_d));
         chk(e2_tag, "dout_en (R3 timing)", 32'(dout_en), 32'(e2_en));
      end
      if (e1_vld) chk("R7", "ext_en", 32'(ext_en), 32'(e1_ext));
      drive_cycle();
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic load_all(int cfg);
      for (int o = 0; o < N; o++) begin
         logic [15:0] w;
         case (cfg)
            1: w = cmw((o * 5 + 3) % N, o != 7, o == 9, o[0], o[1]);
            2: w = cmw((o * 11 + 6) % N, (o != 3) && (o != 7), (o == 12) || (o == 7),
                       !o[0], (o % 3) == 0);
            default: w = cmw(10'h200 | o, 1'b1, 1'b1, o[0], o[2]);
         endcase
         cm_exp[o] = w;
         we_req = 1; addr_req = AW'(o); wdata_req = w;
         tick();
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog R1 actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         cm_exp[i] = '0; pend_vld[i] = 0; pend_fr[i] = 0; pend_val[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R12 reset state, R10 alert idle
      chk("R12", "dout", 32'(dout), 0);
      chk("R12", "dout_en", 32'(dout_en), 0);
      chk("R12", "ext_en", 32'(ext_en), 0);
      chk("R12", "cpu_rdata", 32'(cpu_rdata), 0);
      chk("R10", "cd_n after reset", 32'(cd_n), 1);
      drive_cycle();

      // first configuration
      load_all(1);
      run(3 * N);
      chk_on = 1;
      // R9 read-back and hold
      re_req = 1; addr_req = 4'd5; tick(); tick();
      chk("R9", "rdata entry 5", 32'(cpu_rdata), 32'(cm_exp[5]));
      run(3);
      chk("R9", "rdata held", 32'(cpu_rdata), 32'(cm_exp[5]));
      re_req = 1; addr_req = 4'd9; tick(); tick();
      chk("R9", "rdata entry 9", 32'(cpu_rdata), 32'(cm_exp[9]));
      run(3 * N);
      // R11 acknowledge releases and reference reload holds
      ack_req = 1; tick(); tick();
      chk("R11", "cd_n after ack", 32'(cd_n), 1);
      run(4 * N);
      chk("R10", "cd_n with stable entries", 32'(cd_n), 1);

      // second configuration
      chk_on = 0;
      load_all(2);
      run(3 * N);
      chk_on = 1;
      run(3 * N);
      chk("R10", "cd_n after entry change", 32'(cd_n), 0);
      run(N);
      chk("R10", "cd_n stays low", 32'(cd_n), 0);
      ack_req = 1; tick(); tick();
      chk("R11", "cd_n after ack", 32'(cd_n), 1);
      run(3 * N);
      chk("R11", "cd_n after reload", 32'(cd_n), 1);

      // R8: writes before and after the scan passes the entry
      r8_phase = 1;
      while (cnt != 2) tick();
      we_req = 1; addr_req = 4'd10; wdata_req = cmw(10'h155, 1'b1, 1'b1, 1'b0, 1'b1);
      pend_val[10] = wdata_req; pend_fr[10] = fr + 1; pend_vld[10] = 1;
      tick();
      we_req = 1; addr_req = 4'd1; wdata_req = cmw(0, 1'b1, 1'b0, 1'b1, 1'b1);
      pend_val[1] = wdata_req; pend_fr[1] = fr + 2; pend_vld[1] = 1;
      tick();
      run(4 * N);
      chk("R8", "entries 1 and 10 applied", 32'({cm_exp[1], cm_exp[10]}),
          32'({cmw(0, 1'b1, 1'b0, 1'b1, 1'b1), cmw(10'h155, 1'b1, 1'b1, 1'b0, 1'b1)}));
      chk("R10", "cd_n after processor write", 32'(cd_n), 0);
      r8_phase = 0;
      ack_req = 1; tick();

      // R1 realignment via constant-mode entries echoing the channel
      chk_on = 0;
      load_all(3);
      run(3 * N);
      chk_on = 1;
      run(2 * N);
      while (cnt != 5) tick();
      fp_force = 1;
      tag_over = "R1";
      run(3 * N);
      tag_over = "";
      run(2);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule